// File: doc/BRIEF.md
# Predicated Vector Reduce Unit

This block collapses the active elements of a source vector into a single value using a two-operand operation whose result does not depend on the order of its operands. It holds an element register file, and reads the source vector from that file one element at a time. The active elements are folded in ascending index order, and the final value is written back into the file at the lowest active index of the destination vector. An element is active when its index is below the vector length and its predicate bit is set. Inactive destination slots keep their contents, because there is no zeroing form of predication.

When condition recording is enabled, every fold step produces a three-bit sign classification of the running value. These classifications are merged into one summary field. In "any" mode the merge is a bitwise OR across the steps, and in "all" mode it is a bitwise AND.

The element file is loaded and inspected through a host port while the unit is idle. A reduction starts with a single `start` pulse that carries the vector length, the mask, the operation, the two condition controls and the source and destination base addresses. Completion is signalled by a one-cycle `done`.

Top module: `vred_unit`

## Requirements
- R1: An operation code of 5, 6 or 7 is unsupported. It makes `done` and `illegal_op` high in the cycle after `start` is sampled, and no element of the file is written.
- R2: The result is a strict left-to-right fold over the active elements, taken in ascending index order. The operation codes are: 0 adds with wrap-around, 1 multiplies and keeps the low DW bits, 2 takes the signed minimum, 3 takes the signed maximum, and 4 takes the bitwise OR.
- R3: The reduced value is written to address `dst_base` + (lowest active index), modulo the file depth. The same value is presented on `result` while `done` is high.
- R4: Elements whose predicate bit is clear, and elements at an index at or above `vl`, contribute nothing to the result. The destination slots at those indices keep their previous contents.
- R5: With exactly one active element, that element is copied unchanged to the destination. The condition field is then the sign classification of that element.
- R6: With no active element, nothing is written, `no_active` is high with `done`, and `cr_valid` stays low.
- R7: The condition field is encoded as bit 2 = negative, bit 1 = positive, bit 0 = zero (signed). One classification is made per fold step. With `crm` = 0 the steps are merged by OR, and with `crm` = 1 they are merged by AND. `cr_valid` is high with `done` only when `rc_en` was set and at least one element was active.
- R8: With k active elements, `done` is high in cycle 2k+3 after the cycle in which `start` is sampled. `done` lasts exactly one cycle, and `busy` is high from the cycle after `start` until `done`.
- R9: A `vl` above NELEM behaves as NELEM. A `vl` of 0 makes every element inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write enable into the element file (idle only) |
| host_waddr | input | AW | Host write address |
| host_wdata | input | DW | Host write data |
| host_raddr | input | AW | Host read address (idle only) |
| host_rdata | output | DW | Registered read data, one cycle after the address |
| start | input | 1 | Begin a reduction; sampled while idle |
| vl | input | VLW | Vector length |
| pred | input | NELEM | Predicate mask, bit i for element i |
| op | input | 3 | Operation code |
| rc_en | input | 1 | Record the condition summary |
| crm | input | 1 | 0: merge steps by OR; 1: merge by AND |
| src_base | input | AW | File address of source element 0 |
| dst_base | input | AW | File address of destination element 0 |
| busy | output | 1 | Reduction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Reduced value |
| cr_out | output | 3 | Condition summary |
| cr_valid | output | 1 | Condition summary recorded |
| illegal_op | output | 1 | Last request used an unsupported operation |
| no_active | output | 1 | Last request had no active element |

## Verification
Each active element costs one read cycle and one fold cycle. An unsupported request therefore completes in the cycle after `start`, and a legal request with k active elements completes in cycle 2k+3. After each `start`, the bench counts falling edges until `done` appears and compares that count with the figure computed from the mask and `vl`. It then checks that `done` has dropped one cycle later. The outputs are sampled on the same falling edge that first shows `done`. The destination region is then read back through the registered host port, sampling one cycle after each address, and compared with a bench model in which only the first active slot has changed.

// File: rtl/vred_pkg.sv
package vred_pkg;

  typedef logic [2:0] opc_t;

  localparam opc_t OPC_ADD = 3'd0;
  localparam opc_t OPC_MUL = 3'd1;
  localparam opc_t OPC_MIN = 3'd2;
  localparam opc_t OPC_MAX = 3'd3;
  localparam opc_t OPC_OR  = 3'd4;

  // condition field bit positions
  localparam int CB_NEG  = 2;
  localparam int CB_POS  = 1;
  localparam int CB_ZERO = 0;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_FOLD = 2'd2,
    ST_FIN  = 2'd3
  } vred_state_t;

  function automatic logic opc_ok(input opc_t o);
    return (o <= OPC_OR);
  endfunction

endpackage

// File: rtl/vred_ram.sv
module vred_ram #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/vred_lsb_find.sv
module vred_lsb_find #(
  parameter int N  = 8,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          any
);

  logic [N:0]   seen;
  logic [N-1:0] hit;

  assign seen[0] = 1'b0;

  for (genvar gi = 0; gi < N; gi++) begin : g_chain
    assign seen[gi+1] = seen[gi] | vec[gi];
    assign hit[gi]    = vec[gi] & ~seen[gi];
  end

  assign any = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (hit[i]) idx = idx | IW'(i);
    end
  end

endmodule

// File: rtl/vred_alu.sv
module vred_alu
  import vred_pkg::*;
#(
  parameter int DW = 16
) (
  input  opc_t          op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  output logic [DW-1:0] res
);

  logic [2*DW-1:0] prod;
  logic            a_lt_b;

  assign prod   = a * b;
  assign a_lt_b = $signed(a) < $signed(b);

  always_comb begin
    unique case (op)
      OPC_ADD: res = a + b;
      OPC_MUL: res = prod[DW-1:0];
      OPC_MIN: res = a_lt_b ? a : b;
      OPC_MAX: res = a_lt_b ? b : a;
      OPC_OR:  res = a | b;
      default: res = a;
    endcase
  end

endmodule

// File: rtl/vred_cond.sv
module vred_cond
  import vred_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] val,
  output logic [2:0]    cls
);

  logic is_zero;

  assign is_zero      = (val == '0);
  assign cls[CB_NEG]  = val[DW-1];
  assign cls[CB_ZERO] = is_zero;
  assign cls[CB_POS]  = ~val[DW-1] & ~is_zero;

endmodule

// File: rtl/vred_unit.sv
module vred_unit
  import vred_pkg::*;
#(
  parameter int DW    = 16,
  parameter int NELEM = 8,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH),
  parameter int VLW   = $clog2(NELEM + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             host_we,
  input  logic [AW-1:0]    host_waddr,
  input  logic [DW-1:0]    host_wdata,
  input  logic [AW-1:0]    host_raddr,
  output logic [DW-1:0]    host_rdata,
  input  logic             start,
  input  logic [VLW-1:0]   vl,
  input  logic [NELEM-1:0] pred,
  input  logic [2:0]       op,
  input  logic             rc_en,
  input  logic             crm,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  output logic             busy,
  output logic             done,
  output logic [DW-1:0]    result,
  output logic [2:0]       cr_out,
  output logic             cr_valid,
  output logic             illegal_op,
  output logic             no_active
);

  localparam int IW = (NELEM > 1) ? $clog2(NELEM) : 1;

  vred_state_t      state;
  opc_t             op_q;
  logic             rc_q, crm_q;
  logic [AW-1:0]    src_q, dst_q;
  logic [NELEM-1:0] rem_q, act_q, vl_mask;
  logic [DW-1:0]    acc_q;
  logic [2:0]       cr_acc_q;
  logic             have_acc_q, stepped_q;

  logic [IW-1:0]    rem_idx, first_idx;
  logic             rem_any, act_any;
  logic [DW-1:0]    alu_res, rd_data;
  logic [2:0]       step_cls, acc_cls;
  logic             eng_we;
  logic             ram_we;
  logic [AW-1:0]    ram_waddr, ram_raddr;
  logic [DW-1:0]    ram_wdata;

  // elements at or beyond the vector length are never active
  for (genvar gi = 0; gi < NELEM; gi++) begin : g_vlmask
    assign vl_mask[gi] = (VLW'(gi) < vl);
  end

  vred_lsb_find #(.N(NELEM), .IW(IW)) u_rem_find (
    .vec(rem_q), .idx(rem_idx), .any(rem_any)
  );

  vred_lsb_find #(.N(NELEM), .IW(IW)) u_dst_find (
    .vec(act_q), .idx(first_idx), .any(act_any)
  );

  vred_alu #(.DW(DW)) u_alu (
    .op(op_q), .a(acc_q), .b(rd_data), .res(alu_res)
  );

  vred_cond #(.DW(DW)) u_step_cond (.val(alu_res), .cls(step_cls));
  vred_cond #(.DW(DW)) u_acc_cond  (.val(acc_q),   .cls(acc_cls));

  assign busy   = (state != ST_IDLE);
  assign eng_we = (state == ST_FIN) && act_any;

  always_comb begin
    ram_we    = host_we;
    ram_waddr = host_waddr;
    ram_wdata = host_wdata;
    if (eng_we) begin
      ram_we    = 1'b1;
      ram_waddr = dst_q + AW'(first_idx);
      ram_wdata = acc_q;
    end
    ram_raddr = busy ? (src_q + AW'(rem_idx)) : host_raddr;
  end

  vred_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(ram_raddr), .rdata(rd_data)
  );

  assign host_rdata = rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= OPC_ADD;
      rc_q       <= 1'b0;
      crm_q      <= 1'b0;
      src_q      <= '0;
      dst_q      <= '0;
      rem_q      <= '0;
      act_q      <= '0;
      acc_q      <= '0;
      cr_acc_q   <= '0;
      have_acc_q <= 1'b0;
      stepped_q  <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
      cr_out     <= '0;
      cr_valid   <= 1'b0;
      illegal_op <= 1'b0;
      no_active  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            op_q       <= op;
            rc_q       <= rc_en;
            crm_q      <= crm;
            src_q      <= src_base;
            dst_q      <= dst_base;
            illegal_op <= 1'b0;
            no_active  <= 1'b0;
            cr_valid   <= 1'b0;
            if (!opc_ok(op)) begin
              illegal_op <= 1'b1;
              done       <= 1'b1;
            end else begin
              rem_q      <= pred & vl_mask;
              act_q      <= pred & vl_mask;
              have_acc_q <= 1'b0;
              stepped_q  <= 1'b0;
              state      <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (rem_any) begin
            rem_q[rem_idx] <= 1'b0;
            state          <= ST_FOLD;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_FOLD: begin
          if (!have_acc_q) begin
            acc_q      <= rd_data;
            have_acc_q <= 1'b1;
          end else begin
            acc_q <= alu_res;
            if (!stepped_q) begin
              cr_acc_q  <= step_cls;
              stepped_q <= 1'b1;
            end else if (crm_q) begin
              cr_acc_q <= cr_acc_q & step_cls;
            end else begin
              cr_acc_q <= cr_acc_q | step_cls;
            end
          end
          state <= ST_READ;
        end
        ST_FIN: begin
          done  <= 1'b1;
          state <= ST_IDLE;
          if (act_any) begin
            result   <= acc_q;
            cr_valid <= rc_q;
            cr_out   <= rc_q ? (stepped_q ? cr_acc_q : acc_cls) : 3'b000;
          end else begin
            no_active <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: leaving the busy phase always coincides with completion
  a_r8_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  // R1: an unsupported code finishes at once, flagged, without entering the loop
  a_r1_illegal_fast: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && start && op > OPC_OR) |=> (done && illegal_op && !busy));

  // R6: an empty request never wrote the file in its final cycle
  a_r6_empty_no_write: assert property (@(posedge clk) disable iff (rst)
    (done && no_active) |-> !$past(eng_we));

  // R3: the engine only writes a slot whose predicate bit is set
  a_r3_write_active_slot: assert property (@(posedge clk) disable iff (rst)
    eng_we |-> act_q[first_idx]);

  // R7: a condition summary is only reported when recording was requested
  a_r7_cr_needs_rc: assert property (@(posedge clk) disable iff (rst)
    cr_valid |-> rc_q);

  // R2: a signed minimum step never exceeds either operand
  a_r2_min_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FOLD && have_acc_q && op_q == OPC_MIN) |->
      ($signed(alu_res) <= $signed(acc_q) && $signed(alu_res) <= $signed(rd_data)));

endmodule

// File: tb/vred_unit_tb_top.sv
module vred_unit_tb_top;

  localparam int DW    = 16;
  localparam int NELEM = 4;
  localparam int DEPTH = 32;
  localparam int AW    = $clog2(DEPTH);
  localparam int VLW   = $clog2(NELEM + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             host_we = 1'b0;
  logic [AW-1:0]    host_waddr = '0;
  logic [DW-1:0]    host_wdata = '0;
  logic [AW-1:0]    host_raddr = '0;
  logic [DW-1:0]    host_rdata;
  logic             start = 1'b0;
  logic [VLW-1:0]   vl = '0;
  logic [NELEM-1:0] pred = '0;
  logic [2:0]       op = '0;
  logic             rc_en = 1'b0;
  logic             crm = 1'b0;
  logic [AW-1:0]    src_base = '0;
  logic [AW-1:0]    dst_base = '0;
  logic             busy, done, cr_valid, illegal_op, no_active;
  logic [DW-1:0]    result;
  logic [2:0]       cr_out;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [DW-1:0] src_val [NELEM];

  vred_unit #(.DW(DW), .NELEM(NELEM), .DEPTH(DEPTH), .AW(AW), .VLW(VLW)) dut_i (
    .clk(clk), .rst(rst), .host_we(host_we), .host_waddr(host_waddr),
    .host_wdata(host_wdata), .host_raddr(host_raddr), .host_rdata(host_rdata),
    .start(start), .vl(vl), .pred(pred), .op(op), .rc_en(rc_en), .crm(crm),
    .src_base(src_base), .dst_base(dst_base), .busy(busy), .done(done),
    .result(result), .cr_out(cr_out), .cr_valid(cr_valid),
    .illegal_op(illegal_op), .no_active(no_active)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 190000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=<190000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  function automatic logic [DW-1:0] fold(input int o, input logic [DW-1:0] a,
                                         input logic [DW-1:0] b);
    logic [2*DW-1:0] p;
    p = a * b;
    case (o)
      0: return a + b;
      1: return p[DW-1:0];
      2: return ($signed(a) < $signed(b)) ? a : b;
      3: return ($signed(a) > $signed(b)) ? a : b;
      default: return a | b;
    endcase
  endfunction

  function automatic logic [2:0] classify(input logic [DW-1:0] v);
    if (v == '0) return 3'b001;
    if (v[DW-1]) return 3'b100;
    return 3'b010;
  endfunction

  // all tasks start and end just after a falling edge
  task automatic hwrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    host_we = 1'b1; host_waddr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic hread(input logic [AW-1:0] a, output logic [DW-1:0] d);
    host_raddr = a;
    @(negedge clk);
    d = host_rdata;
  endtask

  task automatic run_one(input int o, input int m, input int v, input int rcv,
                         input int crmv, input logic [AW-1:0] sb,
                         input logic [AW-1:0] db);
    int k, first, n, eff_vl, steps;
    logic [DW-1:0] acc, rd;
    logic [2:0] cr;
    logic legal;
    legal  = (o <= 4);
    eff_vl = (v > NELEM) ? NELEM : v;
    k = 0; first = -1; steps = 0; acc = '0; cr = '0;
    for (int i = 0; i < NELEM; i++) begin
      if (i < eff_vl && m[i]) begin
        if (k == 0) begin
          acc = src_val[i]; first = i;
        end else begin
          acc = fold(o, acc, src_val[i]);
          if (steps == 0) cr = classify(acc);
          else if (crmv != 0) cr = cr & classify(acc);
          else cr = cr | classify(acc);
          steps++;
        end
        k++;
      end
    end
    if (k == 1) cr = classify(acc);
    // sentinel the destination region
    for (int i = 0; i < NELEM; i++) hwrite(db + AW'(i), DW'(16'hA5A0 + i));
    start = 1'b1; vl = VLW'(v); pred = NELEM'(m); op = 3'(o);
    rc_en = rcv[0]; crm = crmv[0]; src_base = sb; dst_base = db;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    while (!done && n < 40) begin
      @(negedge clk);
      n++;
    end
    if (!legal) begin
      check("R1 latency", n, 1);
      check("R1 illegal_op", illegal_op, 1);
    end else begin
      check("R8 latency", n, 2 * k + 3);
      check("R6 no_active", no_active, (k == 0));
      check("R1 illegal_op clear", illegal_op, 0);
      if (k > 0) begin
        check("R2 result", result, acc);
        check("R7 cr_valid", cr_valid, rcv[0]);
        if (rcv[0]) check((k == 1) ? "R5 cr single" : "R7 cr summary", cr_out, cr);
      end else begin
        check("R6 cr_valid", cr_valid, 0);
      end
    end
    @(negedge clk);
    check("R8 done pulse", done, 0);
    check("R8 busy idle", busy, 0);
    for (int i = 0; i < NELEM; i++) begin
      hread(db + AW'(i), rd);
      if (legal && i == first)
        check((k == 1) ? "R5 copy" : "R3 dest write", rd, acc);
      else
        check((v > NELEM) ? "R9 dest kept" : "R4 dest kept", rd, DW'(16'hA5A0 + i));
    end
  endtask

  initial begin
    logic [AW-1:0] sb, db;
    int r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R8 reset done", done, 0);
    check("R8 reset busy", busy, 0);
    check("R6 reset no_active", no_active, 0);
    check("R1 reset illegal", illegal_op, 0);
    check("R7 reset cr_valid", cr_valid, 0);
    r = 0;
    for (int pat = 0; pat < 2; pat++) begin
      sb = (pat == 0) ? AW'(0) : AW'(16);
      db = (pat == 0) ? AW'(8) : AW'(28);
      for (int i = 0; i < NELEM; i++) begin
        if (pat == 0) src_val[i] = DW'((i == 0) ? 3 : (i == 1) ? -5 : (i == 2) ? 0 : 7);
        else          src_val[i] = DW'((i == 0) ? -2 : (i == 1) ? 16'h7FFF : (i == 2) ? -1 : 2);
        hwrite(sb + AW'(i), src_val[i]);
      end
      for (int o = 0; o < 8; o++)
        for (int m = 0; m < 16; m++)
          for (int v = 0; v < 6; v++) begin
            run_one(o, m, v, r % 2, (r / 2) % 2, sb, db);
            r++;
          end
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule